// File: doc/BRIEF.md
# Fully Associative Cache Lookup

This block is a small fully associative cache over a 16-bit word address space. The low four address bits pick one word of a 16-word block, and the remaining twelve bits form the tag. There is no index field, so any memory block may sit in any line. A lookup compares its tag against the stored tag of every valid line at once. In the same cycle it returns the hit flag, the number of the matching line and the addressed word.

On a miss, the surrounding logic refills a line through a word-indexed write port. It writes words 0 to 15 in order, and the write of word 15 carries the block's tag. The line to be written is given on `victim_line`:
- while any line is invalid, it is the lowest-numbered invalid line;
- once every line is valid, a round-robin pointer picks the line, and the pointer moves on after each such replacement.

A synchronous flush empties the cache.

Top module: `assoc_cache`

## Requirements
- R1: After reset every line is invalid, `hit` is 0 for every address and `victim_line` is 0.
- R2: With `lookup_req` high, `hit` is 1 in the same cycle exactly when a valid line holds a tag equal to `lookup_addr[15:4]`. `hit_line` then gives that line's number, and at most one line matches.
- R3: On a hit, `rd_word` gives the word at position `lookup_addr[3:0]` of the matching line, in the same cycle.
- R4: When `lookup_req` is 0 or no valid line matches, `hit` is 0 and `rd_word` is 0.
- R5: A refill write (`fill_we` = 1) stores `fill_data` at word `fill_widx` of line `victim_line`. The write of word 15 makes the line valid with tag `fill_tag` from the next cycle onwards.
- R6: While at least one line is invalid, `victim_line` is the lowest-numbered invalid line.
- R7: When every line is valid, `victim_line` follows a round-robin pointer. The pointer is 0 after reset or flush and steps by one, wrapping after the last line, each time a refill that began on a full cache completes.
- R8: `flush` = 1 invalidates every line and returns the pointer to 0 at the next edge. It takes precedence over a refill's word-15 write in the same cycle, which then leaves the line invalid.
- R9: The write of word 0 invalidates the target line from the next cycle until word 15 is written, so its old block no longer hits during the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines |
| lookup_req | input | 1 | Lookup request |
| lookup_addr | input | 16 | Word address looked up |
| hit | output | 1 | Lookup hit |
| hit_line | output | 2 | Line number of the hit |
| rd_word | output | 16 | Addressed word on a hit, else 0 |
| fill_we | input | 1 | Refill word write |
| fill_widx | input | 4 | Word position being refilled |
| fill_tag | input | 12 | Tag of the refilled block, taken with word 15 |
| fill_data | input | 16 | Refill word |
| victim_line | output | 2 | Line that a refill writes |

## Verification
The completion of a refill (the word-15 write) and a flush can fall on the same edge. The bench provokes this by writing words 0 to 14 of a block and then raising `flush` together with word 15. After that edge it requires a miss on the refilled tag and a victim line of 0, which shows that the flush won. A second overlap, a lookup of the line being replaced during its refill, is judged by requiring a miss on the old tag after word 0 is written.

// File: rtl/assoc_cache.sv
module assoc_cache #(
  parameter int LINES = 4,
  parameter int AW    = 16,
  parameter int OFFW  = 4,
  parameter int DW    = 16,
  localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int TAGW = AW - OFFW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            lookup_req,
  input  logic [AW-1:0]   lookup_addr,
  output logic            hit,
  output logic [LW-1:0]   hit_line,
  output logic [DW-1:0]   rd_word,
  input  logic            fill_we,
  input  logic [OFFW-1:0] fill_widx,
  input  logic [TAGW-1:0] fill_tag,
  input  logic [DW-1:0]   fill_data,
  output logic [LW-1:0]   victim_line
);
  localparam int WPL = 1 << OFFW;

  logic [LINES-1:0] valid;
  logic [TAGW-1:0]  tag_q [LINES];
  logic [DW-1:0]    mem   [LINES][WPL];
  logic [LW-1:0]    rr;
  logic             full_q;
  logic [LINES-1:0] match;
  logic [LW-1:0]    first_inv;
  logic             all_valid, commit, start;

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_cmp
      assign match[g] = valid[g] && (tag_q[g] == lookup_addr[AW-1:OFFW]);
    end
  endgenerate

  always_comb begin
    hit_line  = '0;
    first_inv = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i])  hit_line  = LW'(i);
      if (!valid[i]) first_inv = LW'(i);
    end
  end

  assign all_valid   = &valid;
  assign victim_line = all_valid ? rr : first_inv;
  assign hit         = lookup_req && (|match);
  assign rd_word     = hit ? mem[hit_line][lookup_addr[OFFW-1:0]] : '0;
  assign start       = fill_we && (fill_widx == '0);
  assign commit      = fill_we && (fill_widx == OFFW'(WPL - 1));

  always_ff @(posedge clk)
    if (fill_we) mem[victim_line][fill_widx] <= fill_data;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid  <= '0;
      rr     <= '0;
      full_q <= 1'b0;
    end else begin
      if (start) begin
        valid[victim_line] <= 1'b0;
        full_q             <= all_valid;
      end
      if (commit) begin
        valid[victim_line] <= 1'b1;
        tag_q[victim_line] <= fill_tag;
        if (full_q) rr <= (rr == LW'(LINES - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

  // R2: at most one matching line
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R5: completed refill leaves line valid with its tag
  a_r5_commit_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !flush) |=> (valid[$past(victim_line)] && tag_q[$past(victim_line)] == $past(fill_tag)));

  // R7: pointer advances after replacement in a full cache
  a_r7_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && full_q && !flush) |=>
      (rr == (($past(rr) == LW'(LINES - 1)) ? '0 : $past(rr) + 1'b1)));

  // R8: flush empties the cache
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid == '0 && rr == '0));

  // R9: refill start invalidates target line
  a_r9_start_inval: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !flush) |=> !valid[$past(victim_line)]);
endmodule

// File: tb/test_assoc_cache.sv
module test_assoc_cache;
  logic        clk = 0, rst_n = 0, flush = 0, lookup_req = 0, fill_we = 0;
  logic [15:0] lookup_addr = '0, fill_data = '0;
  logic [3:0]  fill_widx = '0;
  logic [11:0] fill_tag = '0;
  logic        hit;
  logic [1:0]  hit_line, victim_line;
  logic [15:0] rd_word;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  assoc_cache i_assoc_cache (.*);

  function automatic logic [15:0] pat(input logic [11:0] t, input logic [3:0] w);
    return {t, w} ^ 16'h5A5A;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic req, input logic [15:0] a);
    @(negedge clk);
    lookup_req = req; lookup_addr = a;
    #5;
  endtask

  task automatic write_word(input logic [11:0] t, input logic [3:0] w, input logic fl);
    @(negedge clk);
    fill_we = 1; fill_widx = w; fill_data = pat(t, w);
    fill_tag = (w == 4'hF) ? t : 12'h000; flush = fl;
    @(negedge clk);
    fill_we = 0; flush = 0;
  endtask

  task automatic fill_block(input logic [11:0] t);
    for (int w = 0; w < 16; w++) write_word(t, 4'(w), 1'b0);
  endtask

  task automatic t_reset;
    look(1, 16'h0000); chk("R1 hit", hit, 0); chk("R1 victim", victim_line, 0);
    look(1, 16'hFFF3); chk("R1 hit2", hit, 0); chk("R4 rd", rd_word, 0);
  endtask

  task automatic t_first_fill;
    fill_block(12'h123);
    for (int w = 0; w < 16; w++) begin
      look(1, {12'h123, 4'(w)});
      chk("R2 hit", hit, 1); chk("R2 line", hit_line, 0);
      chk("R3 word", rd_word, pat(12'h123, 4'(w)));
    end
    chk("R6 victim after one", victim_line, 1);
  endtask

  task automatic t_miss;
    look(1, 16'h1245); chk("R4 tag miss", hit, 0); chk("R4 tag miss rd", rd_word, 0);
    look(0, 16'h1235); chk("R4 no req", hit, 0); chk("R4 no req rd", rd_word, 0);
  endtask

  task automatic t_fill_rest;
    fill_block(12'h200); chk("R6 victim 2", victim_line, 2);
    fill_block(12'h300); chk("R6 victim 3", victim_line, 3);
    fill_block(12'h400); chk("R7 full victim 0", victim_line, 0);
    look(1, 16'h300A); chk("R2 line2 hit", hit, 1); chk("R2 line2", hit_line, 2);
    chk("R5 data", rd_word, pat(12'h300, 4'hA));
    look(1, 16'h400F); chk("R5 line3", hit_line, 3);
  endtask

  task automatic t_replace;
    write_word(12'h500, 4'h0, 1'b0);
    look(1, 16'h1237); chk("R9 old tag misses mid-refill", hit, 0);
    chk("R9 victim held", victim_line, 0);
    for (int w = 1; w < 16; w++) write_word(12'h500, 4'(w), 1'b0);
    look(1, 16'h5004); chk("R5 new hit", hit, 1); chk("R5 new line", hit_line, 0);
    chk("R5 new data", rd_word, pat(12'h500, 4'h4));
    look(1, 16'h1234); chk("R7 evicted", hit, 0);
    chk("R7 victim advanced", victim_line, 1);
    fill_block(12'h600); chk("R7 victim 2", victim_line, 2);
    look(1, 16'h6001); chk("R7 line1 replaced", hit_line, 1);
    fill_block(12'h700); fill_block(12'h800);
    chk("R7 wrap", victim_line, 0);
  endtask

  task automatic t_flush;
    @(negedge clk); flush = 1; @(negedge clk); flush = 0;
    look(1, 16'h5000); chk("R8 flushed", hit, 0); chk("R8 victim", victim_line, 0);
    for (int w = 0; w < 15; w++) write_word(12'h900, 4'(w), 1'b0);
    write_word(12'h900, 4'hF, 1'b1);
    look(1, 16'h9003); chk("R8 flush beats commit", hit, 0);
    chk("R8 victim after race", victim_line, 0);
    fill_block(12'hA00);
    look(1, 16'hA002); chk("R6 refill after flush", hit_line, 0);
    chk("R6 next victim", victim_line, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_first_fill; t_miss; t_fill_rest; t_replace; t_flush;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule